// File: doc/BRIEF.md
# ID Code Access Gate

The gate stands between an external programming host and a command decoder. It decides whether host commands may proceed. The host first sends an identification sequence of seven bytes. The gate checks each byte against a reference byte kept in protected memory. It reads that reference byte through a simple port addressed by byte position, and the read returns data one cycle later.

A single sticky flag records any mismatch. Once all seven bytes have been checked and none of them differed, access is granted. Any later command request then receives a one-cycle accept pulse. Without a grant, the request receives a one-cycle reject pulse instead, and the accept line stays low. A refused command therefore has no effect downstream.

When the protected memory reports that it is blank, the comparison result is ignored and every command is accepted. A restart strobe begins a new sequence and withdraws any earlier grant. A reset also withdraws the grant.

Top module: `idgate_top`

## Requirements
- R1: While reset is active and on the first cycle after it, with `mem_blank` low: `access_granted`, `cmd_accept`, `cmd_reject` and `ref_rd_en` are low and `id_ready` is high.
- R2: An ID byte is taken in the cycle where `id_valid` and `id_ready` are both high. In that same cycle `ref_rd_en` is high and `ref_rd_idx` equals the byte's 0-based position in the sequence. `id_ready` is low for the following cycle, during which `ref_rd_data` must carry the reference byte.
- R3: After the seventh byte has been compared, with no mismatch at any position, `access_granted` is high from the next cycle on. It is low before the seventh comparison.
- R4: A difference in any bit of any position leaves `access_granted` low after the seventh byte. The mismatch is not cleared by matching bytes that come later.
- R5: `id_start` clears the grant, the mismatch flag and the position counter at the next clock edge. It wins over `id_valid` in the same cycle, and no read is issued in that cycle.
- R6: Once seven bytes have been compared, `id_ready` stays low and further `id_valid` bytes are ignored: no read, no change to the grant. This lasts until `id_start`.
- R7: While `mem_blank` is high, `access_granted` is high whatever the ID state, and commands are accepted.
- R8: A `cmd_valid` cycle produces, one cycle later, a one-cycle pulse on exactly one of `cmd_accept` and `cmd_reject`. It is `cmd_accept` if and only if `access_granted` was high in the request cycle.
- R9: A refused command raises `cmd_reject` only and never `cmd_accept`. With no `cmd_valid`, both outputs are low in the following cycle.
- R10: Reset withdraws a grant that was obtained before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| id_start | input | 1 | Begin a new ID sequence |
| id_valid | input | 1 | ID byte present on `id_byte` |
| id_byte | input | 8 | Received ID byte |
| id_ready | output | 1 | Gate can take an ID byte this cycle |
| ref_rd_en | output | 1 | Reference read request |
| ref_rd_idx | output | 3 | Reference byte position |
| ref_rd_data | input | 8 | Reference byte, valid the cycle after the request |
| mem_blank | input | 1 | Protected memory is blank |
| cmd_valid | input | 1 | Host command request |
| cmd_accept | output | 1 | Command accepted pulse |
| cmd_reject | output | 1 | Command refused pulse |
| access_granted | output | 1 | Commands currently allowed |

## Verification
On every cycle, the assertions check the following properties. The grant only exists in the completed state. A mismatch stays set. A restart clears both the grant and the mismatch. The completed state holds. Each command verdict is unique and agrees with the grant seen in the request cycle.

Only the bench scenarios can show the other properties. These are the read positions in arrival order and that the comparison uses the delayed memory data. They also include that a single flipped bit at any position blocks access, the blank bypass, the ignored surplus bytes, and the loss of the grant across reset.

// File: rtl/idgate_pkg.sv
// Shared types for the ID code access gate.
package idgate_pkg;
    // Sequencer phases: ready for a byte, waiting on the reference read, sequence complete.
    typedef enum logic [1:0] {
        S_COLLECT = 2'd0,
        S_FETCH   = 2'd1,
        S_DONE    = 2'd2
    } idg_state_e;
endpackage

// File: rtl/idgate_seq.sv
// ID sequencer and comparator.
// Takes ID bytes one at a time and fetches the matching reference byte.
// It compares the two when the read data returns and keeps a sticky mismatch flag.
// After the last position it raises id_ok if nothing differed.
// Assumes: the read port returns data exactly one cycle after ref_rd_en.
module idgate_seq
    import idgate_pkg::*;
#(
    parameter int ID_LEN = 7,
    parameter int BYTE_W = 8,
    localparam int IDX_W = (ID_LEN > 1) ? $clog2(ID_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_start,
    input  logic              id_valid,
    input  logic [BYTE_W-1:0] id_byte,
    output logic              id_ready,
    output logic              ref_rd_en,
    output logic [IDX_W-1:0]  ref_rd_idx,
    input  logic [BYTE_W-1:0] ref_rd_data,
    output logic              id_ok
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ID_LEN - 1);

    idg_state_e        state_q;
    logic [IDX_W-1:0]  idx_q;
    logic [BYTE_W-1:0] held_q;
    logic              miss_q;
    logic              ok_q;
    logic              miss_n;

    // Handshake and read request: only in the collect phase, and never while a restart is requested.
    always_comb begin
        id_ready   = (state_q == S_COLLECT);
        ref_rd_en  = id_valid && id_ready && !id_start;
        ref_rd_idx = idx_q;
        miss_n     = miss_q || (ref_rd_data != held_q);
        id_ok      = ok_q;
    end

    // Sequencing, comparison and verdict registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_COLLECT;
            idx_q   <= '0;
            held_q  <= '0;
            miss_q  <= 1'b0;
            ok_q    <= 1'b0;
        end else if (id_start) begin
            state_q <= S_COLLECT;
            idx_q   <= '0;
            miss_q  <= 1'b0;
            ok_q    <= 1'b0;
        end else begin
            case (state_q)
                S_COLLECT: begin
                    if (id_valid) begin
                        held_q  <= id_byte;
                        state_q <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    miss_q <= miss_n;
                    if (idx_q == LAST) begin
                        state_q <= S_DONE;
                        ok_q    <= !miss_n;
                    end else begin
                        idx_q   <= idx_q + IDX_W'(1);
                        state_q <= S_COLLECT;
                    end
                end
                default: begin
                    state_q <= S_DONE;
                end
            endcase
        end
    end

    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        idx_q <= LAST); // R2
    AST_GRANT_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ok_q |-> (state_q == S_DONE)); // R3
    AST_MISS_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_q && !id_start) |=> miss_q); // R4
    AST_START_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        id_start |=> (!ok_q && !miss_q && idx_q == '0)); // R5
    AST_DONE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_DONE && !id_start) |=> (state_q == S_DONE && $stable(ok_q))); // R6
endmodule

// File: rtl/idgate_cmd.sv
// Command filter.
// Turns each command request into a registered accept or reject pulse, based on the permission level present in the request cycle.
// Assumes: allow is stable across the request cycle edge.
module idgate_cmd (
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_valid,
    input  logic allow,
    output logic cmd_accept,
    output logic cmd_reject
);
    // One-cycle verdict pulses, cleared by reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_accept <= 1'b0;
            cmd_reject <= 1'b0;
        end else begin
            cmd_accept <= cmd_valid && allow;
            cmd_reject <= cmd_valid && !allow;
        end
    end

    AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmd_accept && cmd_reject)); // R8
    AST_ACCEPT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_accept |-> $past(allow && cmd_valid)); // R8
    AST_REJECT_RULE: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_reject |-> $past(!allow && cmd_valid)); // R9
endmodule

// File: rtl/idgate_top.sv
// ID code access gate top.
// Combines the ID sequencer with the command filter.
// A blank protected memory bypasses the ID result.
// Assumes: mem_blank is a quasi-static level from the memory controller.
module idgate_top #(
    parameter int ID_LEN = 7,
    parameter int BYTE_W = 8,
    localparam int IDX_W = (ID_LEN > 1) ? $clog2(ID_LEN) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              id_start,
    input  logic              id_valid,
    input  logic [BYTE_W-1:0] id_byte,
    output logic              id_ready,
    output logic              ref_rd_en,
    output logic [IDX_W-1:0]  ref_rd_idx,
    input  logic [BYTE_W-1:0] ref_rd_data,
    input  logic              mem_blank,
    input  logic              cmd_valid,
    output logic              cmd_accept,
    output logic              cmd_reject,
    output logic              access_granted
);
    logic id_ok;

    idgate_seq #(.ID_LEN(ID_LEN), .BYTE_W(BYTE_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .id_start    (id_start),
        .id_valid    (id_valid),
        .id_byte     (id_byte),
        .id_ready    (id_ready),
        .ref_rd_en   (ref_rd_en),
        .ref_rd_idx  (ref_rd_idx),
        .ref_rd_data (ref_rd_data),
        .id_ok       (id_ok)
    );

    // Permission: blank memory bypasses the ID check.
    always_comb begin
        access_granted = mem_blank || id_ok;
    end

    idgate_cmd u_cmd (
        .clk        (clk),
        .rst_n      (rst_n),
        .cmd_valid  (cmd_valid),
        .allow      (access_granted),
        .cmd_accept (cmd_accept),
        .cmd_reject (cmd_reject)
    );
endmodule

// File: tb/idgate_top_tb.sv
`timescale 1ns/1ps
module idgate_top_tb;
    localparam int ID_LEN = 7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       id_start = 1'b0;
    logic       id_valid = 1'b0;
    logic [7:0] id_byte = '0;
    logic       id_ready;
    logic       ref_rd_en;
    logic [2:0] ref_rd_idx;
    logic [7:0] ref_rd_data = '0;
    logic       mem_blank = 1'b0;
    logic       cmd_valid = 1'b0;
    logic       cmd_accept;
    logic       cmd_reject;
    logic       access_granted;

    int n_checks = 0;
    int n_fails  = 0;

    always #2 clk = ~clk;

    idgate_top u_dut (
        .clk(clk), .rst_n(rst_n), .id_start(id_start), .id_valid(id_valid),
        .id_byte(id_byte), .id_ready(id_ready), .ref_rd_en(ref_rd_en),
        .ref_rd_idx(ref_rd_idx), .ref_rd_data(ref_rd_data), .mem_blank(mem_blank),
        .cmd_valid(cmd_valid), .cmd_accept(cmd_accept), .cmd_reject(cmd_reject),
        .access_granted(access_granted)
    );

    function automatic logic [7:0] ref_val(int i);
        return 8'((60 + i * 37) % 256);
    endfunction

    // Protected memory model: one cycle read latency.
    always @(posedge clk) begin
        if (ref_rd_en) ref_rd_data <= ref_val(int'(ref_rd_idx));
    end

    task automatic chk(input bit ok, input string req, input int got, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: got %0d expected %0d at %0t", req, got, exp, $time);
        end
    endtask

    // Send a full sequence, optionally XOR-ing mask into one position (pos < 0: none).
    task automatic run_id(input int pos, input logic [7:0] mask, input bit exp_grant);
        @(negedge clk) id_start = 1'b1;
        @(negedge clk) id_start = 1'b0;
        chk(id_ready == 1'b1, "R5 ready after start", int'(id_ready), 1);
        for (int i = 0; i < ID_LEN; i++) begin
            id_valid = 1'b1;
            id_byte  = ref_val(i) ^ ((i == pos) ? mask : 8'h00);
            #1;
            chk(ref_rd_en == 1'b1, "R2 read request", int'(ref_rd_en), 1);
            chk(int'(ref_rd_idx) == i, "R2 read index", int'(ref_rd_idx), i);
            @(negedge clk) id_valid = 1'b0;
            chk(id_ready == 1'b0, "R2 busy during fetch", int'(id_ready), 0);
            @(negedge clk);
            if (i < ID_LEN - 1) begin
                chk(access_granted == mem_blank, "R3 no grant before last", int'(access_granted), int'(mem_blank));
                chk(id_ready == 1'b1, "R2 ready again", int'(id_ready), 1);
            end else begin
                chk(id_ready == 1'b0, "R6 ready low after last", int'(id_ready), 0);
            end
        end
        chk(access_granted == exp_grant, (exp_grant ? "R3 grant" : "R4 mismatch blocks"),
            int'(access_granted), int'(exp_grant));
    endtask

    task automatic do_cmd(input bit exp_acc);
        @(negedge clk) cmd_valid = 1'b1;
        @(negedge clk) cmd_valid = 1'b0;
        chk(cmd_accept == exp_acc, "R8 accept", int'(cmd_accept), int'(exp_acc));
        chk(cmd_reject == !exp_acc, "R9 reject", int'(cmd_reject), int'(!exp_acc));
        @(negedge clk);
        chk(!cmd_accept && !cmd_reject, "R9 idle verdict", int'({cmd_accept, cmd_reject}), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        chk(!access_granted && !cmd_accept && !cmd_reject && !ref_rd_en, "R1 reset outputs",
            int'({access_granted, cmd_accept, cmd_reject, ref_rd_en}), 0);
        chk(id_ready == 1'b1, "R1 ready in reset", int'(id_ready), 1);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!access_granted && id_ready, "R1 after reset", int'(access_granted), 0);
        do_cmd(1'b0);

        // R3: correct sequence grants access
        run_id(-1, 8'h00, 1'b1);
        do_cmd(1'b1);

        // R4: every single-bit flip at every position blocks access
        for (int p = 0; p < ID_LEN; p++) begin
            for (int b = 0; b < 8; b++) begin
                run_id(p, 8'(1 << b), 1'b0);
                do_cmd(1'b0);
            end
        end
        // R4: sticky mismatch with full byte inversion at first and last positions
        run_id(0, 8'hFF, 1'b0);
        run_id(ID_LEN - 1, 8'hFF, 1'b0);

        // R6: surplus bytes ignored after completion
        run_id(-1, 8'h00, 1'b1);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk) id_valid = 1'b1; id_byte = 8'hA5;
            #1 chk(ref_rd_en == 1'b0, "R6 no read after done", int'(ref_rd_en), 0);
        end
        @(negedge clk) id_valid = 1'b0;
        chk(access_granted == 1'b1, "R6 grant unchanged", int'(access_granted), 1);
        chk(id_ready == 1'b0, "R6 still not ready", int'(id_ready), 0);

        // R5: start clears grant; start wins over a same-cycle byte
        @(negedge clk) id_start = 1'b1; id_valid = 1'b1; id_byte = ref_val(0);
        #1 chk(ref_rd_en == 1'b0, "R5 no read with start", int'(ref_rd_en), 0);
        @(negedge clk) id_start = 1'b0; id_valid = 1'b0;
        chk(access_granted == 1'b0, "R5 grant cleared", int'(access_granted), 1 - 1);
        do_cmd(1'b0);
        @(negedge clk) id_valid = 1'b1; id_byte = ref_val(0);
        #1 chk(int'(ref_rd_idx) == 0, "R5 index cleared", int'(ref_rd_idx), 0);
        @(negedge clk) id_valid = 1'b0;
        @(negedge clk);

        // R7: blank memory bypasses mismatch, also mid-sequence
        mem_blank = 1'b1;
        #1 chk(access_granted == 1'b1, "R7 blank mid-sequence", int'(access_granted), 1);
        run_id(3, 8'h10, 1'b1);
        do_cmd(1'b1);
        mem_blank = 1'b0;
        #1 chk(access_granted == 1'b0, "R7 blank removed", int'(access_granted), 0);
        do_cmd(1'b0);

        // R10: reset withdraws a grant
        run_id(-1, 8'h00, 1'b1);
        @(negedge clk) rst_n = 1'b0;
        @(negedge clk) rst_n = 1'b1;
        chk(access_granted == 1'b0, "R10 grant lost on reset", int'(access_granted), 0);
        do_cmd(1'b0);
        run_id(-1, 8'h00, 1'b1);
        do_cmd(1'b1);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end
endmodule